// File: doc/BRIEF.md
# Load/Store Alignment Trap Detector

The block inspects one memory-access instruction per cycle and decides whether it must raise an alignment trap. Each instruction carries a class (non-memory, ordinary load/store, load/store multiple, load/store string, or reserve-load/conditional-store), an access size, the two low bits of its effective address, the current little-endian mode flag, and a flag that marks a higher-priority exception already pending for the same instruction.

The trap decision depends on the class and the endian mode together. In little-endian mode, multiple and string instructions always trap, and an ordinary access traps when it is misaligned. In big-endian mode, only a misaligned multiple or a misaligned reserve/conditional access traps. A registered request and a valid strobe come out one cycle after each input. The access itself, the fault-status encoding and the memory traffic are handled elsewhere.

Top module: `align_trap_top`

## Requirements
- R1: During reset and in the cycle after reset is released, `trap_req` and `out_vld` are 0.
- R2: `out_vld` equals `in_vld` delayed by one clock, and `trap_req` is 0 in any cycle where `out_vld` is 0.
- R3: Alignment is judged by size code `acc_size` (0 = byte, 1 = halfword, 2 = word, 3 = doubleword). A byte is always aligned. A halfword needs `ea_lo[0]`=0. A word or doubleword needs `ea_lo[1:0]`=0.
- R4: Class `OP_MULTI` (code 2), the load/store multiple class, is treated as a word access. It traps when `ea_lo[1:0]` is not 0, in either endian mode.
- R5: Class `OP_RESV` (code 4), the reserve-load/conditional-store class, is treated as a word access. It traps when `ea_lo[1:0]` is not 0, in either endian mode.
- R6: With `le_mode`=1, classes `OP_MULTI` and `OP_STRING` (code 3) always trap, whatever the address.
- R7: Class `OP_PLAIN` (code 1) traps when misaligned under R3 and `le_mode`=1. With `le_mode`=0 it never traps.
- R8: With `le_mode`=0, `OP_STRING` never traps.
- R9: Class `OP_NONE` (code 0) never traps.
- R10: When `hi_pend`=1 the trap request is 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | An instruction is presented this cycle |
| op_class | input | 3 | Instruction class code |
| acc_size | input | 2 | Access size code |
| ea_lo | input | 2 | Low effective-address bits |
| le_mode | input | 1 | Little-endian mode flag |
| hi_pend | input | 1 | Higher-priority exception pending |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| trap_req | output | 1 | Alignment trap request |

## Verification
Both results, `out_vld` and `trap_req`, are due exactly one clock edge after their input was applied. The bench drives inputs on the falling edge and pushes each expected pair into a queue. On the next falling edge, which lies one rising edge later, it pops the pair and compares it with the outputs. The stimulus covers every combination of class, size, address, mode and pending flag, idle gaps and a random stream, so each output is checked in the cycle its input predicts.

// File: rtl/align_trap_pkg.sv
package align_trap_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PLAIN  = 3'd1,
        OP_MULTI  = 3'd2,
        OP_STRING = 3'd3,
        OP_RESV   = 3'd4
    } op_class_e;

    localparam int SZ_W = 2;
    localparam int EA_W = 2;

    typedef struct packed {
        logic vld;
        logic trap;
    } trap_state_t;
endpackage

// File: rtl/align_check.sv
module align_check
    import align_trap_pkg::*;
#(
    parameter int SZ_BITS = SZ_W,
    parameter int EA_BITS = EA_W
) (
    input  logic [SZ_BITS-1:0] size_code,
    input  logic [EA_BITS-1:0] ea_low,
    output logic               misaligned
);
    logic [EA_BITS-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < EA_BITS; i++) begin
            if (i < int'(size_code)) mask[i] = 1'b1;
        end
        misaligned = |(ea_low & mask);
    end
endmodule

// File: rtl/trap_rules.sv
module trap_rules
    import align_trap_pkg::*;
#(
    parameter int SZ_BITS = SZ_W,
    parameter int EA_BITS = EA_W
) (
    input  logic [2:0]         op_class,
    input  logic [SZ_BITS-1:0] acc_size,
    input  logic [EA_BITS-1:0] ea_lo,
    input  logic               le_mode,
    input  logic               hi_pend,
    output logic               trap
);
    localparam logic [SZ_BITS-1:0] WORD_CODE = SZ_BITS'(2);

    logic mis_sized;
    logic mis_word;

    align_check #(.SZ_BITS(SZ_BITS), .EA_BITS(EA_BITS)) u_sized (
        .size_code(acc_size), .ea_low(ea_lo), .misaligned(mis_sized));
    align_check #(.SZ_BITS(SZ_BITS), .EA_BITS(EA_BITS)) u_word (
        .size_code(WORD_CODE), .ea_low(ea_lo), .misaligned(mis_word));

    logic raw;
    always_comb begin
        case (op_class)
            OP_PLAIN:  raw = le_mode & mis_sized;
            OP_MULTI:  raw = le_mode | mis_word;
            OP_STRING: raw = le_mode;
            OP_RESV:   raw = mis_word;
            default:   raw = 1'b0;
        endcase
        trap = raw & ~hi_pend;
    end
endmodule

// File: rtl/align_trap_top.sv
module align_trap_top
    import align_trap_pkg::*;
#(
    parameter int SZ_BITS = SZ_W,
    parameter int EA_BITS = EA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [2:0]         op_class,
    input  logic [SZ_BITS-1:0] acc_size,
    input  logic [EA_BITS-1:0] ea_lo,
    input  logic               le_mode,
    input  logic               hi_pend,
    output logic               out_vld,
    output logic               trap_req
);
    logic        trap_c;
    trap_state_t st_d, st_q;

    trap_rules #(.SZ_BITS(SZ_BITS), .EA_BITS(EA_BITS)) u_rules (
        .op_class(op_class), .acc_size(acc_size), .ea_lo(ea_lo),
        .le_mode(le_mode), .hi_pend(hi_pend), .trap(trap_c));

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_vld;
        st_d.trap = in_vld & trap_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign trap_req = st_q.trap;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !trap_req));
    a_r2_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(in_vld)));
    a_r2_trap_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> out_vld);
    a_r10_pend_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hi_pend |=> !trap_req);
    a_r9_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd0) |=> !trap_req);
    a_r6_le_multi_string: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && le_mode && !hi_pend && (op_class == 3'd2 || op_class == 3'd3))
        |=> trap_req);
    a_r5_resv_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !hi_pend && op_class == 3'd4 && ea_lo != '0) |=> trap_req);
    a_r8_be_string: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd3 && !le_mode) |=> !trap_req);
endmodule

// File: tb/align_trap_top_test.sv
module align_trap_top_test;
    logic clk = 0, rst_n = 0, in_vld = 0, le_mode = 0, hi_pend = 0;
    logic [2:0] op_class = 0;
    logic [1:0] acc_size = 0, ea_lo = 0;
    logic out_vld, trap_req;
    int checks = 0, fails = 0;
    bit exp_q[$];
    bit expv_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    align_trap_top uut (.clk, .rst_n, .in_vld, .op_class, .acc_size, .ea_lo,
                        .le_mode, .hi_pend, .out_vld, .trap_req);

    function automatic bit model(int cls, int sz, int ea, bit le, bit pend);
        bit mis_s, mis_w, t;
        mis_s = (sz == 0) ? 0 : (sz == 1) ? (ea % 2 != 0) : (ea != 0);
        mis_w = (ea != 0);
        case (cls)
            1: t = le && mis_s;          // R7, R3
            2: t = le || mis_w;          // R4, R6
            3: t = le;                   // R6, R8
            4: t = mis_w;                // R5
            default: t = 0;              // R9
        endcase
        return t && !pend;               // R10
    endfunction

    task automatic chk(bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic drive(bit v, int cls, int sz, int ea, bit le, bit pend);
        @(negedge clk);
        if (expv_q.size() > 0) begin
            bit ev = expv_q.pop_front();
            bit et = exp_q.pop_front();
            chk(out_vld, ev, "R2 out_vld");
            chk(trap_req, et, (cls == 0) ? "R9/R10 trap_req" : "R3-R8 trap_req");
        end
        in_vld = v; op_class = 3'(cls); acc_size = 2'(sz); ea_lo = 2'(ea);
        le_mode = le; hi_pend = pend;
        expv_q.push_back(v);
        exp_q.push_back(v && model(cls, sz, ea, le, pend));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_vld, 0, "R1 out_vld");
        chk(trap_req, 0, "R1 trap_req");
        rst_n = 1;
        @(negedge clk);
        chk(out_vld, 0, "R1 after release");
        chk(trap_req, 0, "R1 after release");
        for (int c = 0; c < 6; c++)
            for (int s = 0; s < 4; s++)
                for (int e = 0; e < 4; e++)
                    for (int l = 0; l < 2; l++)
                        for (int p = 0; p < 2; p++) begin
                            drive(1, c, s, e, l[0], p[0]);
                            if ((e + p) == 3) drive(0, 2, 0, 1, 1, 0); // R2 gap
                        end
        for (int i = 0; i < 400; i++)
            drive($urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1));
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule